// File: doc/BRIEF.md
# AFSK Tone Divider Generator

This block makes the keyed audio tone for a radioteletype and Morse terminal. A reference tick is divided by an integer count to give a square wave. The tick arrives as a one-cycle enable on the system clock, nominally at 250.125 kHz, which is the 8.004 MHz system clock divided by 32. The count comes from a lookup on the operating mode, the tone range, the shift width, the sense and the live keying bit. An external analog low-pass filter later turns the square wave into a sine.

Settings and the keying bit may change at any time. The block holds the divisor of the running period and loads the new one only when that period ends, so the output never carries a runt pulse. The block also gives a one-cycle pulse at each period start and a flag that stays high once the first period has begun. Control pins are plain levels sampled every cycle. There is no streamed data, so there is no back-pressure.

Encodings used below: `mode` 0 = Morse, 1 = TOR, 2 = FSK (Baudot/ASCII family), 3 = reserved; `shift_sel` 0 = 170 Hz, 1 = 425 Hz, 2 = 850 Hz, 3 = reserved; `tone_hi` 0 = low range, 1 = high range; `key_mark` 1 = mark, 0 = space; `sense_rev` 1 = reversed.

Top module: `afsk_tone_gen`

## Requirements
- R1: While `rst` is high, and after it falls until the first `ref_tick`, `tone_out` and `tone_valid` are low.
- R2: The first `ref_tick` after reset starts a period: `period_start` pulses for one cycle, and `tone_out` and `tone_valid` go high in the cycle after that tick.
- R3: A period of divisor N lasts exactly N ticks. `tone_out` is high for the first floor(N/2) ticks and low for the remaining ticks, so odd N is allowed.
- R4: `tone_out` changes only in the cycle after a clock edge that sampled `ref_tick` high.
- R5: Morse mode (0) gives a mark divisor of 155 (1613.7 Hz) and a space divisor of 302 (828.2 Hz).
- R6: TOR mode (1) gives a mark divisor of 196 (1276.1 Hz) and a space divisor of 140 (1786.6 Hz), whatever the range and shift.
- R7: FSK mode (2) in the low range gives a mark divisor of 196. It gives space divisors of 173, 147 and 118 for `shift_sel` 0, 1 and 2.
- R8: FSK mode (2) in the high range gives a mark divisor of 118. It gives space divisors of 109, 98 and 84 for `shift_sel` 0, 1 and 2.
- R9: When `sense_rev` is 1, the mark and space divisors of the selected pair swap.
- R10: Mode 3, or FSK mode with `shift_sel` 3, uses the Morse pair of R5.
- R11: A change of settings or keying during a period does not alter that period. The new divisor applies from the next period start.
- R12: Once high, `tone_valid` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle reference enable |
| mode | input | 2 | Operating mode code |
| tone_hi | input | 1 | Tone range, 1 = high |
| shift_sel | input | 2 | Shift width code |
| sense_rev | input | 1 | Reversed sense |
| key_mark | input | 1 | Live keying bit, 1 = mark |
| tone_out | output | 1 | Square-wave tone |
| tone_valid | output | 1 | High once a period is running |
| period_start | output | 1 | One-cycle pulse when a period and its divisor begin |

## Verification
The bench builds the block with its defaults: a 250125 Hz reference and a 9-bit counter. This brings the largest divisor, 302, to the top of the counter range and includes odd divisors (155, 173, 147, 109) as well as even ones, so the split between the high and low parts of a period is tested both ways. Each new setting is applied ten ticks into a running period. Every period measured therefore also shows that the period before it kept its old length. The run covers all three modes, both ranges, all shift codes including the reserved one, both senses and the reserved mode.

// File: rtl/afsk_tone_pkg.sv
package afsk_tone_pkg;

  typedef enum logic [1:0] {
    MD_MORSE = 2'd0,
    MD_TOR   = 2'd1,
    MD_FSK   = 2'd2,
    MD_RSVD  = 2'd3
  } afsk_mode_e;

  typedef enum logic [1:0] {
    SH_NARROW = 2'd0,
    SH_MID    = 2'd1,
    SH_WIDE   = 2'd2,
    SH_RSVD   = 2'd3
  } afsk_shift_e;

  typedef struct packed {
    afsk_mode_e  mode;
    logic        tone_hi;
    afsk_shift_e shift;
    logic        sense_rev;
    logic        key_mark;
  } afsk_cfg_t;

  // Tone frequencies in hundredths of a hertz
  localparam int unsigned F_MORSE_HI_CHZ = 161370;
  localparam int unsigned F_MORSE_LO_CHZ = 82820;
  localparam int unsigned F_TOR_SP_CHZ   = 178660;
  localparam int unsigned F_LO_MK_CHZ    = 127610;
  localparam int unsigned F_LO_SP0_CHZ   = 144580;
  localparam int unsigned F_LO_SP1_CHZ   = 170150;
  localparam int unsigned F_LO_SP2_CHZ   = 211970;
  localparam int unsigned F_HI_MK_CHZ    = 211970;
  localparam int unsigned F_HI_SP0_CHZ   = 229470;
  localparam int unsigned F_HI_SP1_CHZ   = 255230;
  localparam int unsigned F_HI_SP2_CHZ   = 297920;

  // Nearest integer count of reference ticks per tone period
  function automatic int unsigned tone_div(input int unsigned ref_hz,
                                           input int unsigned f_chz);
    return (ref_hz * 100 + f_chz / 2) / f_chz;
  endfunction

endpackage

// File: rtl/afsk_div_lut.sv
module afsk_div_lut
  import afsk_tone_pkg::*;
#(
  parameter int unsigned REF_HZ = 250125,
  parameter int unsigned CNT_W  = 9
) (
  input  afsk_cfg_t          cfg,
  output logic [CNT_W-1:0]   div_n
);

  localparam logic [CNT_W-1:0] N_MORSE_MK = CNT_W'(tone_div(REF_HZ, F_MORSE_HI_CHZ));
  localparam logic [CNT_W-1:0] N_MORSE_SP = CNT_W'(tone_div(REF_HZ, F_MORSE_LO_CHZ));
  localparam logic [CNT_W-1:0] N_TOR_SP   = CNT_W'(tone_div(REF_HZ, F_TOR_SP_CHZ));
  localparam logic [CNT_W-1:0] N_LO_MK    = CNT_W'(tone_div(REF_HZ, F_LO_MK_CHZ));
  localparam logic [CNT_W-1:0] N_LO_SP0   = CNT_W'(tone_div(REF_HZ, F_LO_SP0_CHZ));
  localparam logic [CNT_W-1:0] N_LO_SP1   = CNT_W'(tone_div(REF_HZ, F_LO_SP1_CHZ));
  localparam logic [CNT_W-1:0] N_LO_SP2   = CNT_W'(tone_div(REF_HZ, F_LO_SP2_CHZ));
  localparam logic [CNT_W-1:0] N_HI_MK    = CNT_W'(tone_div(REF_HZ, F_HI_MK_CHZ));
  localparam logic [CNT_W-1:0] N_HI_SP0   = CNT_W'(tone_div(REF_HZ, F_HI_SP0_CHZ));
  localparam logic [CNT_W-1:0] N_HI_SP1   = CNT_W'(tone_div(REF_HZ, F_HI_SP1_CHZ));
  localparam logic [CNT_W-1:0] N_HI_SP2   = CNT_W'(tone_div(REF_HZ, F_HI_SP2_CHZ));

  logic [CNT_W-1:0] mark_n;
  logic [CNT_W-1:0] space_n;
  logic [CNT_W-1:0] fsk_space_n;
  logic             fsk_ok;
  logic             want_mark;

  // Space divisor of the FSK family for the selected range and shift
  always_comb begin
    fsk_ok      = 1'b1;
    fsk_space_n = N_MORSE_SP;
    unique case (cfg.shift)
      SH_NARROW: fsk_space_n = cfg.tone_hi ? N_HI_SP0 : N_LO_SP0;
      SH_MID:    fsk_space_n = cfg.tone_hi ? N_HI_SP1 : N_LO_SP1;
      SH_WIDE:   fsk_space_n = cfg.tone_hi ? N_HI_SP2 : N_LO_SP2;
      default:   fsk_ok      = 1'b0;
    endcase
  end

  // Mark/space pair for the mode; reserved codes fall back to Morse
  always_comb begin
    mark_n  = N_MORSE_MK;
    space_n = N_MORSE_SP;
    unique case (cfg.mode)
      MD_TOR: begin
        mark_n  = N_LO_MK;
        space_n = N_TOR_SP;
      end
      MD_FSK: begin
        if (fsk_ok) begin
          mark_n  = cfg.tone_hi ? N_HI_MK : N_LO_MK;
          space_n = fsk_space_n;
        end
      end
      default: begin
        mark_n  = N_MORSE_MK;
        space_n = N_MORSE_SP;
      end
    endcase
  end

  assign want_mark = cfg.key_mark ^ cfg.sense_rev;
  assign div_n     = want_mark ? mark_n : space_n;

endmodule

// File: rtl/afsk_period_ctr.sv
module afsk_period_ctr #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] div_next,
  output logic             wave,
  output logic             running,
  output logic             pstart
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_n;
  logic [CNT_W-1:0] half_n;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] next_half;
  logic             at_end;

  always_comb begin
    cnt_inc   = cnt + 1'b1;
    last_idx  = cur_n - 1'b1;
    next_half = div_next >> 1;
    at_end    = !running || (cnt == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_n   <= '0;
      half_n  <= '0;
      running <= 1'b0;
      wave    <= 1'b0;
      pstart  <= 1'b0;
    end else begin
      pstart <= 1'b0;
      if (tick) begin
        if (at_end) begin
          cur_n   <= div_next;
          half_n  <= next_half;
          cnt     <= '0;
          running <= 1'b1;
          pstart  <= 1'b1;
          wave    <= (next_half != '0);
        end else begin
          cnt  <= cnt_inc;
          wave <= (cnt_inc < half_n);
        end
      end
    end
  end

endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen
  import afsk_tone_pkg::*;
#(
  parameter int unsigned REF_HZ = 250125,
  parameter int unsigned CNT_W  = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic [1:0] mode,
  input  logic       tone_hi,
  input  logic [1:0] shift_sel,
  input  logic       sense_rev,
  input  logic       key_mark,
  output logic       tone_out,
  output logic       tone_valid,
  output logic       period_start
);

  afsk_cfg_t        cfg;
  logic [CNT_W-1:0] div_n;

  always_comb begin
    cfg.mode      = afsk_mode_e'(mode);
    cfg.tone_hi   = tone_hi;
    cfg.shift     = afsk_shift_e'(shift_sel);
    cfg.sense_rev = sense_rev;
    cfg.key_mark  = key_mark;
  end

  afsk_div_lut #(
    .REF_HZ (REF_HZ),
    .CNT_W  (CNT_W)
  ) u_lut (
    .cfg   (cfg),
    .div_n (div_n)
  );

  afsk_period_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .tick     (ref_tick),
    .div_next (div_n),
    .wave     (tone_out),
    .running  (tone_valid),
    .pstart   (period_start)
  );

endmodule

// File: rtl/afsk_tone_gen_chk.sv
module afsk_tone_gen_chk (
  input logic clk,
  input logic rst,
  input logic ref_tick,
  input logic tone_out,
  input logic tone_valid,
  input logic period_start
);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!tone_out && !tone_valid));

  // R4
  tone_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(tone_out));

  // R2
  start_level_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (tone_out && tone_valid));

  // R11
  start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(period_start) |-> $past(ref_tick));

  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tone_valid |=> tone_valid);

endmodule

bind afsk_tone_gen afsk_tone_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ref_tick     (ref_tick),
  .tone_out     (tone_out),
  .tone_valid   (tone_valid),
  .period_start (period_start)
);

// File: tb/sim_afsk_tone_gen.sv
module sim_afsk_tone_gen;

  localparam int CLK_P = 10;
  localparam int NCFG  = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       tone_hi = 1'b0;
  logic [1:0] shift_sel = 2'd0;
  logic       sense_rev = 1'b0;
  logic       key_mark = 1'b1;
  logic       tone_out;
  logic       tone_valid;
  logic       period_start;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    ticks_en = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  afsk_tone_gen u0 (
    .clk          (clk),
    .rst          (rst),
    .ref_tick     (ref_tick),
    .mode         (mode),
    .tone_hi      (tone_hi),
    .shift_sel    (shift_sel),
    .sense_rev    (sense_rev),
    .key_mark     (key_mark),
    .tone_out     (tone_out),
    .tone_valid   (tone_valid),
    .period_start (period_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected divisor from the requirement tables (R5..R10)
  function automatic int exp_div(input int md, input bit hi, input int sh,
                                 input bit rev, input bit key);
    int mk, sp;
    mk = 155; sp = 302;
    if (md == 1) begin mk = 196; sp = 140; end
    else if (md == 2 && sh != 3) begin
      mk = hi ? 118 : 196;
      case (sh)
        0: sp = hi ? 109 : 173;
        1: sp = hi ? 98  : 147;
        default: sp = hi ? 84 : 118;
      endcase
    end
    return (key ^ rev) ? mk : sp;
  endfunction

  // Reference tick: every second clock while enabled
  initial begin
    forever begin
      @(negedge clk);
      ref_tick = ticks_en ? ~ref_tick : 1'b0;
    end
  end

  // Monitor: measures each period and compares with the scoreboard
  initial begin
    int    cur_exp;
    string cur_tag;
    int    len_c, hi_c;
    bit    prev_tick, prev_out;
    cur_exp = -1; cur_tag = ""; len_c = 0; hi_c = 0;
    prev_tick = 1'b0; prev_out = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        cur_exp = -1; len_c = 0; hi_c = 0;
      end else begin
        // R4: output may only move after a sampled tick
        if (tone_out != prev_out)
          check(prev_tick, "R4 change without tick", int'(tone_out), int'(prev_out));
        if (period_start) begin
          if (cur_exp > 0) begin
            check(len_c == 2 * cur_exp, {"R3 R11 period length ", cur_tag}, len_c / 2, cur_exp);
            check(hi_c == 2 * (cur_exp / 2), {"R3 high time ", cur_tag}, hi_c / 2, cur_exp / 2);
          end
          check(tone_out && tone_valid, "R2 level at period start",
                int'({tone_out, tone_valid}), 3);
          if (exp_q.size() > 0) begin
            cur_exp = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
          end else begin
            cur_exp = -1;
          end
          len_c = 1;
          hi_c  = tone_out ? 1 : 0;
        end else begin
          len_c++;
          if (tone_out) hi_c++;
        end
      end
      prev_tick = ref_tick;
      prev_out  = tone_out;
    end
  end

  // Watchdog
  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  // Driver
  initial begin
    int    c_md [NCFG] = '{0, 0, 0, 0, 1, 1, 1, 2, 2, 2, 2, 2, 2, 2, 2, 2, 2, 3};
    bit    c_hi [NCFG] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0};
    int    c_sh [NCFG] = '{0, 0, 0, 0, 0, 2, 3, 0, 1, 2, 1, 2, 0, 1, 2, 2, 3, 1};
    bit    c_rv [NCFG] = '{0, 0, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
    bit    c_ky [NCFG] = '{1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1, 0};
    string c_tg [NCFG] = '{"R5", "R5", "R9", "R9", "R6", "R6", "R6 R9",
                           "R7", "R7", "R7", "R7", "R8", "R8", "R8", "R8",
                           "R8 R9", "R10", "R10"};

    repeat (4) @(negedge clk);
    check(!tone_out && !tone_valid, "R1 during reset", int'({tone_out, tone_valid}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!tone_out && !tone_valid && !period_start, "R1 before first tick",
          int'({tone_out, tone_valid, period_start}), 0);

    mode = 2'(c_md[0]); tone_hi = c_hi[0]; shift_sel = 2'(c_sh[0]);
    sense_rev = c_rv[0]; key_mark = c_ky[0];
    exp_q.push_back(exp_div(c_md[0], c_hi[0], c_sh[0], c_rv[0], c_ky[0]));
    tag_q.push_back(c_tg[0]);
    ticks_en = 1'b1;

    for (int i = 1; i < NCFG; i++) begin
      do @(negedge clk); while (!period_start);
      repeat (20) @(negedge clk);   // apply mid-period (R11)
      mode = 2'(c_md[i]); tone_hi = c_hi[i]; shift_sel = 2'(c_sh[i]);
      sense_rev = c_rv[i]; key_mark = c_ky[i];
      exp_q.push_back(exp_div(c_md[i], c_hi[i], c_sh[i], c_rv[i], c_ky[i]));
      tag_q.push_back(c_tg[i]);
    end
    for (int k = 0; k < 2; k++) begin
      do @(negedge clk); while (!period_start);
    end
    repeat (5) @(negedge clk);
    check(tone_valid, "R12 valid held", int'(tone_valid), 1);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!tone_out && !tone_valid, "R1 after late reset", int'({tone_out, tone_valid}), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule